// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block drives an external successive-approximation converter core from a single 16-bit control word. It derives a conversion clock from the input clock through a programmable power-of-two divider. It holds the core in its sample phase for a programmable number of those divided clocks, then in a convert phase of fixed length, and then flags one result. The selected input mode is passed straight through to the core.

A conversion can be started by one of several sources. Four of them are hardware events: an external start pin, two timer event lines and a programmable-logic event line. These are sensed on their rising edge. The other two are software sources. One-shot software mode runs one conversion and then sets its own trigger field back to the pin code. Continuous mode restarts the next conversion as soon as the previous one finishes.

Every start is gated by an enable bit, by the power bit, and by a settling interval that follows power-up. Clearing the enable bit does not stop a continuous run that is already going. Clearing the power bit aborts any conversion at once.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control word reads 0x0600 (divider code 001, acquisition code 10, every other field zero), and sample, convert and result-valid are low.
- R2: The read value always shows bits 15:13 and bit 6 as zero. Every other bit holds the last value written, reserved codes included, so writing 0xFFFF reads back as 0x1FBF.
- R3: The trigger field in bits 2:0 picks the source: 000 pin, 001 timer 1, 010 timer 0, 101 programmable logic. A hardware source starts a conversion on the rising edge of its line. Rising edges on lines that are not selected start nothing.
- R4: The conversion sequence works as follows:
  - A hardware edge sampled at clock edge k raises sample from edge k, for A×D cycles, where A is the acquisition length and D is the divide factor.
  - Convert then stays high for 14×D cycles. Sample and convert are never high together.
  - Result-valid is a one-cycle pulse that starts at edge k+(A+14)×D.
- R5: Divider field bits 12:10 give D = 1, 2, 4, 8, 16, 32 for codes 000 to 101. The reserved codes 110 and 111 divide by 32.
- R6: Acquisition field bits 9:8 give A = 2, 4, 8, 16 for codes 00 to 11.
- R7: While enable bit 7 is clear, no trigger of any kind starts a conversion from idle.
- R8: Power bit 5 is handled as follows:
  - While bit 5 is clear, sample and convert stay low and triggers are ignored.
  - For SETTLE_CYC cycles after bit 5 is set, triggers are still ignored.
  - Clearing bit 5 during a conversion aborts it at once, with no result-valid.
- R9: Trigger code 011 starts one conversion. Its start comes one cycle after the write. When that conversion ends, the field reads 000, so no further software conversion follows, and a later pin edge starts a conversion.
- R10: Trigger code 100 starts conversions back to back. Each new one begins on the cycle after the previous result. Clearing the enable bit does not stop the run. Changing the trigger code ends the run after the conversion in progress.
- R11: A trigger edge that arrives while a conversion is running is dropped and is not remembered.
- R12: Trigger codes 110 and 111 start nothing. The two-bit input-mode field in bits 4:3 appears unchanged on core_mode, including the reserved code 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word to write |
| rd_data | output | 16 | Current control word, reserved bits as zero |
| pin_start | input | 1 | External start pin |
| tmr0_evt | input | 1 | Timer 0 event line |
| tmr1_evt | input | 1 | Timer 1 event line |
| logic_evt | input | 1 | Programmable-logic event line |
| core_sample | output | 1 | Core in acquisition phase |
| core_convert | output | 1 | Core in conversion phase |
| core_mode | output | 2 | Input mode passed to the core |
| result_valid | output | 1 | One-cycle result strobe |

## Verification
Some properties are checked on every cycle:
- Sample and convert never overlap.
- Result-valid is one cycle long and always follows a convert cycle.
- Nothing runs while the power bit reads clear.
- A start from idle occurs only with the enable bit set.
- A finished one-shot conversion leaves the trigger field at 000.

Other behaviour needs the bench's scenarios:
- Exact phase lengths for each divider and acquisition code.
- Source selection and the rejection of edges on lines that are not selected.
- The settling window.
- The abort on power-down.
- Dropping of edges while busy.
- The back-to-back rate of continuous mode after the enable bit is cleared.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int SETTLE_CYC = 210,
  parameter int CONV_CLKS  = 14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  input  logic        pin_start,
  input  logic        tmr0_evt,
  input  logic        tmr1_evt,
  input  logic        logic_evt,
  output logic        core_sample,
  output logic        core_convert,
  output logic [1:0]  core_mode,
  output logic        result_valid
);
  localparam int SW     = $clog2(SETTLE_CYC + 1);
  localparam int PH_MAX = (CONV_CLKS > 16) ? CONV_CLKS : 16;
  localparam int PHW    = $clog2(PH_MAX);
  localparam logic [2:0] T_PIN = 3'b000, T_TM1 = 3'b001, T_TM0 = 3'b010,
                         T_ONE = 3'b011, T_RUN = 3'b100, T_PLA = 3'b101;

  typedef enum logic [1:0] {S_IDLE, S_ACQ, S_CONV} state_t;

  state_t         state_q;
  logic [2:0]     div_q, type_q;
  logic [1:0]     acq_q, mode_q;
  logic           en_q, pwr_q;
  logic [4:0]     pre_q, pre_top;
  logic [PHW-1:0] ph_q, acq_last;
  logic [SW-1:0]  settle_q;
  logic [3:0]     prev_q, rise;
  logic           pwr_d, tick, ready, sel_edge, go;
  logic           unused_bits;

  assign unused_bits = ^{wr_data[15:13], wr_data[6]};

  assign rd_data = {3'b000, div_q, acq_q, en_q, 1'b0, pwr_q, mode_q, type_q};
  assign core_mode    = mode_q;
  assign core_sample  = (state_q == S_ACQ);
  assign core_convert = (state_q == S_CONV);

  assign pwr_d = wr_en ? wr_data[5] : pwr_q;
  assign rise  = {logic_evt, tmr0_evt, tmr1_evt, pin_start} & ~prev_q;
  assign ready = pwr_q && (settle_q == SW'(SETTLE_CYC));
  assign tick  = (pre_q == pre_top);

  always_comb begin
    case (div_q)
      3'b000:  pre_top = 5'd0;
      3'b001:  pre_top = 5'd1;
      3'b010:  pre_top = 5'd3;
      3'b011:  pre_top = 5'd7;
      3'b100:  pre_top = 5'd15;
      default: pre_top = 5'd31;
    endcase
  end

  always_comb begin
    case (acq_q)
      2'b00:   acq_last = PHW'(1);
      2'b01:   acq_last = PHW'(3);
      2'b10:   acq_last = PHW'(7);
      default: acq_last = PHW'(15);
    endcase
  end

  always_comb begin
    case (type_q)
      T_PIN:   sel_edge = rise[0];
      T_TM1:   sel_edge = rise[1];
      T_TM0:   sel_edge = rise[2];
      T_PLA:   sel_edge = rise[3];
      T_ONE:   sel_edge = 1'b1;
      T_RUN:   sel_edge = 1'b1;
      default: sel_edge = 1'b0;
    endcase
  end

  assign go = (state_q == S_IDLE) && ready && en_q && sel_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= 3'b001;
      acq_q    <= 2'b10;
      en_q     <= 1'b0;
      pwr_q    <= 1'b0;
      mode_q   <= 2'b00;
      type_q   <= T_PIN;
      settle_q <= '0;
      prev_q   <= '0;
    end else begin
      prev_q <= {logic_evt, tmr0_evt, tmr1_evt, pin_start};
      if (!pwr_d)
        settle_q <= '0;
      else if (settle_q != SW'(SETTLE_CYC))
        settle_q <= settle_q + 1'b1;
      if (wr_en) begin
        div_q  <= wr_data[12:10];
        acq_q  <= wr_data[9:8];
        en_q   <= wr_data[7];
        pwr_q  <= wr_data[5];
        mode_q <= wr_data[4:3];
        type_q <= wr_data[2:0];
      end else if (state_q == S_CONV && tick && ph_q == PHW'(CONV_CLKS - 1)
                   && type_q == T_ONE) begin
        type_q <= T_PIN;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= S_IDLE;
      pre_q        <= '0;
      ph_q         <= '0;
      result_valid <= 1'b0;
    end else begin
      result_valid <= 1'b0;
      if (!pwr_d) begin
        state_q <= S_IDLE;
        pre_q   <= '0;
        ph_q    <= '0;
      end else begin
        case (state_q)
          S_IDLE: begin
            pre_q <= '0;
            ph_q  <= '0;
            if (go) state_q <= S_ACQ;
          end
          S_ACQ: begin
            pre_q <= tick ? 5'd0 : pre_q + 5'd1;
            if (tick) begin
              if (ph_q == acq_last) begin
                state_q <= S_CONV;
                ph_q    <= '0;
              end else begin
                ph_q <= ph_q + 1'b1;
              end
            end
          end
          S_CONV: begin
            pre_q <= tick ? 5'd0 : pre_q + 5'd1;
            if (tick) begin
              if (ph_q == PHW'(CONV_CLKS - 1)) begin
                result_valid <= 1'b1;
                ph_q         <= '0;
                state_q      <= (type_q == T_RUN && ready) ? S_ACQ : S_IDLE;
              end else begin
                ph_q <= ph_q + 1'b1;
              end
            end
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       en_bit,
  input logic       pwr_bit,
  input logic [2:0] type_f,
  input logic       core_sample,
  input logic       core_convert,
  input logic       result_valid
);
  a_r4_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(core_sample && core_convert));

  a_r4_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  a_r4_valid_after_conv: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> $past(core_convert));

  a_r8_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_bit |-> (!core_sample && !core_convert));

  a_r7_start_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(core_sample) && !$past(core_convert)) |-> $past(en_bit));

  a_r9_one_shot_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && $past(type_f == 3'b011) && !$past(wr_en)) |-> (type_f == 3'b000));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
  .en_bit(rd_data[7]), .pwr_bit(rd_data[5]), .type_f(rd_data[2:0]),
  .core_sample(core_sample), .core_convert(core_convert),
  .result_valid(result_valid)
);

// File: tb/test_adc_seq_ctrl.sv
`timescale 1ns/1ps
module test_adc_seq_ctrl;
  localparam int SETTLE = 210;
  localparam int CONV   = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [3:0]  trig = '0;
  logic        core_sample, core_convert, result_valid;
  logic [1:0]  core_mode;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  adc_seq_ctrl #(.SETTLE_CYC(SETTLE), .CONV_CLKS(CONV)) i_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .pin_start(trig[0]), .tmr0_evt(trig[2]), .tmr1_evt(trig[1]), .logic_evt(trig[3]),
    .core_sample(core_sample), .core_convert(core_convert), .core_mode(core_mode),
    .result_valid(result_valid)
  );

  function automatic int ctrl(int dv, int aq, int en, int pw, int md, int ty);
    return (dv << 10) | (aq << 8) | (en << 7) | (pw << 5) | (md << 3) | ty;
  endfunction
  function automatic int exp_div(int code);
    return (code >= 5) ? 32 : (1 << code);
  endfunction
  function automatic int exp_acq(int code);
    return 2 << code;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int v);
    @(negedge clk); wr_en = 1'b1; wr_data = v[15:0];
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse(int idx);
    @(negedge clk); trig[idx] = 1'b1;
    @(negedge clk); trig[idx] = 1'b0;
  endtask

  task automatic quiet(int cyc, string req);
    int act = 0;
    repeat (cyc) begin
      @(negedge clk);
      if (core_sample || core_convert || result_valid) act++;
    end
    check(act == 0, req, act, 0);
  endtask

  task automatic measure(int dcode, int acode, string req);
    int n = 1, s = 0, c = 0;
    int d = exp_div(dcode);
    int a = exp_acq(acode);
    while (!result_valid && n < 3000) begin
      if (core_sample) s++;
      if (core_convert) c++;
      @(negedge clk); n++;
    end
    check(s == a * d, {req, " sample length"}, s, a * d);
    check(c == CONV * d, {req, " convert length"}, c, CONV * d);
    check(n == (a + CONV) * d + 1, {req, " result latency"}, n, (a + CONV) * d + 1);
    @(negedge clk);
    check(!result_valid, "R4 valid pulse width", int'(result_valid), 0);
  endtask

  task automatic wait_valid();
    int n = 0;
    while (!result_valid && n < 3000) begin @(negedge clk); n++; end
  endtask

  initial begin
    #(5ns * 190000);
    total++; bad++;
    $display("FAIL R4 watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cnt;
    int codes[4] = '{0, 1, 2, 5};
    void'($urandom(32'h5EED));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_data == 16'h0600, "R1 reset word", rd_data, 16'h0600);
    check(!core_sample && !core_convert && !result_valid, "R1 idle outputs", 1, 0);

    wr(16'hFFFF);
    check(rd_data == 16'h1FBF, "R2 readback", rd_data, 16'h1FBF);

    wr(0);
    wr(ctrl(0, 0, 1, 1, 0, 0));
    pulse(0);
    quiet(40, "R8 settling ignores trigger");
    repeat (SETTLE + 10) @(negedge clk);
    pulse(0);
    measure(0, 0, "R8 after settling");

    wr(ctrl(0, 0, 0, 1, 0, 0));
    pulse(0);
    quiet(40, "R7 enable clear");

    for (int i = 0; i < 16; i++) begin
      int dv = $urandom_range(0, 7);
      int aq = $urandom_range(0, 3);
      int src = $urandom_range(0, 3);
      int oth = (src + 1 + $urandom_range(0, 2)) % 4;
      wr(ctrl(dv, aq, 1, 1, 0, codes[src]));
      pulse(oth);
      quiet(6, "R3 unselected source");
      pulse(src);
      measure(dv, aq, "R3 R5 R6 random");
    end

    wr(ctrl(7, 3, 1, 1, 0, 0));
    pulse(0);
    measure(7, 3, "R5 reserved divider");
    wr(ctrl(6, 1, 1, 1, 0, 5));
    pulse(3);
    measure(6, 1, "R5 R6 logic source");

    wr(ctrl(2, 3, 1, 1, 0, 0));
    pulse(0);
    repeat (10) @(negedge clk);
    pulse(0);
    wait_valid();
    quiet(100, "R11 busy edge dropped");

    wr(ctrl(0, 1, 1, 1, 0, 3));
    @(negedge clk);
    measure(0, 1, "R9 one-shot");
    check(rd_data[2:0] == 3'b000, "R9 field cleared", rd_data[2:0], 0);
    quiet(30, "R9 no repeat");
    pulse(0);
    measure(0, 1, "R9 pin after one-shot");

    wr(ctrl(0, 0, 1, 1, 0, 4));
    wait_valid();
    wr(ctrl(0, 0, 0, 1, 0, 4));
    cnt = 0;
    repeat (96) begin @(negedge clk); if (result_valid) cnt++; end
    check(cnt == 6, "R10 continuous with enable clear", cnt, 6);
    wr(ctrl(0, 0, 0, 1, 0, 0));
    repeat (40) @(negedge clk);
    quiet(40, "R10 run stopped");

    wr(ctrl(5, 3, 1, 1, 0, 0));
    pulse(0);
    repeat (20) @(negedge clk);
    wr(ctrl(5, 3, 1, 0, 0, 0));
    check(!core_sample && !core_convert, "R8 abort", int'(core_sample), 0);
    quiet(1200, "R8 no result after abort");
    pulse(0);
    quiet(20, "R8 powered down trigger");

    wr(ctrl(0, 0, 1, 1, 0, 6));
    repeat (SETTLE + 10) @(negedge clk);
    for (int k = 0; k < 4; k++) pulse(k);
    quiet(30, "R12 code 110");
    wr(ctrl(0, 0, 1, 1, 3, 7));
    for (int k = 0; k < 4; k++) pulse(k);
    quiet(30, "R12 code 111");
    check(core_mode == 2'd3, "R12 mode 11", core_mode, 3);
    wr(ctrl(0, 0, 1, 1, 1, 0));
    check(core_mode == 2'd1, "R12 mode 01", core_mode, 1);
    pulse(0);
    measure(0, 0, "R12 after reserved");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule